// File: doc/BRIEF.md
# Host Controller Interrupt Aggregator

This block collects six event sources of a USB host controller into one level-sensitive interrupt line toward the host. Each source has a sticky status flag, set by a one-cycle event pulse from the controller core, and an enable bit. Software reaches the status, enable and threshold registers through a plain 32-bit register port. It acknowledges an event by writing a one to that event's status bit.

The sources fall into two groups. Host system error, frame list rollover and port change assert the interrupt as soon as their flag and enable are both set. Transfer-complete, USB error and async-advance are deferred. A local counter of microframe ticks marks interval boundaries, and a deferred source counts only from the first boundary that follows its flag being set. The interval length is programmable.

Top module: `usb_irq_aggregator`

## Requirements
- R1: After reset the enable register (byte offset 0x28) and the status register (byte offset 0x24) read 0, the threshold register (byte offset 0x2C) reads 8, and `irq_out` is low.
- R2: Enable bits 5:0 are writable and read back at 0x28. Bits 31:6 of that register always read 0.
- R3: An `evt_pulse[i]` sets status bit i (bit 0 transfer-complete, 1 USB error, 2 port change, 3 frame list rollover, 4 host system error, 5 async-advance), whatever the state of its enable bit. The flag stays set until software clears it.
- R4: Writing to 0x24 clears each status bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged.
- R5: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: For bits 2, 3 and 4, `irq_out` is high in the cycle right after the clock edge at which the flag and its enable bit are both set.
- R7: For bits 0, 1 and 5, `irq_out` rises only at the first interval boundary after the flag was set. A boundary is the clock edge at which `uframe_tick` is high and completes the programmed number of ticks.
- R8: Bits 6:0 of 0x2C set the interval in ticks and read back as written. The legal values are 1, 2, 4, 8, 16, 32 and 64. Any other value gives an interval of 8 ticks.
- R9: Clearing an enable bit removes that source from `irq_out` from the next clock on. Its status flag is left unchanged.
- R10: `irq_out` falls after the edge at which the last enabled, qualified flag is cleared. A deferred flag that is set again must wait for a new boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pulse | input | 6 | One-cycle event strobes from the controller core |
| uframe_tick | input | 1 | One-cycle microframe tick |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq_out | output | 1 | Level interrupt to the host |

## Verification
On every cycle, the assertions check the following:
- an interrupt never stands without an enabled flag behind it;
- reserved enable bits read zero;
- events always latch, and clearing writes clear;
- turning off every enable silences the line at once;
- a rise caused only by deferred sources coincides with a boundary.

Only the bench scenarios can show the following:
- the exact boundary on which a deferred source fires for each interval setting, including the fallback for illegal values;
- set-over-clear priority;
- a deferred source that is re-armed has to wait for a fresh boundary.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    localparam int NUM_SRC = 6;
    localparam int THR_W   = 7;
    localparam int ADDR_W  = 8;

    // sources whose interrupt waits for an interval boundary
    localparam logic [NUM_SRC-1:0] DEFER_MASK = 6'b100011;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 8'h24;
    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 8'h28;
    localparam logic [ADDR_W-1:0] ADDR_THRESH = 8'h2C;

    localparam int DEF_SEL = 3;   // fallback interval is 1 << DEF_SEL ticks
    localparam logic [THR_W-1:0] THR_RESET = THR_W'(1) << DEF_SEL;

    typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_tick_divider.sv
module irq_tick_divider
    import usb_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [THR_W-1:0] thr_raw,
    output logic             boundary
);
    typedef struct packed {
        logic [THR_W-1:0] cnt;
    } div_state_t;

    div_state_t       st_d, st_q;
    logic [THR_W-1:0] eff;

    always_comb begin
        eff      = $onehot(thr_raw) ? thr_raw : THR_RESET;
        boundary = tick && (st_q.cnt >= eff - 1'b1);
        st_d     = st_q;
        if (tick) begin
            st_d.cnt = boundary ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import usb_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t set_pulse,
    input  src_vec_t clr_mask,
    input  logic     boundary,
    output src_vec_t status,
    output src_vec_t qual_next
);
    typedef struct packed {
        src_vec_t status;
        src_vec_t qual;
    } bank_state_t;

    bank_state_t st_d, st_q;
    src_vec_t    status_nx;

    // a set in the same cycle as a clear wins
    assign status_nx = set_pulse | (st_q.status & ~clr_mask);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (DEFER_MASK[i]) begin : g_defer
            assign qual_next[i] = status_nx[i] &
                                  (st_q.qual[i] | (boundary & st_q.status[i]));
        end else begin : g_now
            assign qual_next[i] = status_nx[i];
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.status = status_nx;
        st_d.qual   = qual_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.status;
endmodule

// File: rtl/usb_irq_aggregator.sv
module usb_irq_aggregator
    import usb_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] evt_pulse,
    input  logic              uframe_tick,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out
);
    typedef struct packed {
        src_vec_t         enable;
        logic [THR_W-1:0] thr;
        logic             irq;
    } top_state_t;

    top_state_t st_d, st_q;
    src_vec_t   status_now;
    src_vec_t   qual_next;
    src_vec_t   clr_mask;
    logic       tick_boundary;
    logic       wr_status, wr_enable, wr_thresh;
    logic       unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:THR_W];

    assign wr_status = reg_wr_en && (reg_addr == ADDR_STATUS);
    assign wr_enable = reg_wr_en && (reg_addr == ADDR_ENABLE);
    assign wr_thresh = reg_wr_en && (reg_addr == ADDR_THRESH);
    assign clr_mask  = wr_status ? reg_wdata[NUM_SRC-1:0] : '0;

    irq_tick_divider i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (uframe_tick),
        .thr_raw  (st_q.thr),
        .boundary (tick_boundary)
    );

    irq_status_bank i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (evt_pulse),
        .clr_mask  (clr_mask),
        .boundary  (tick_boundary),
        .status    (status_now),
        .qual_next (qual_next)
    );

    always_comb begin
        st_d = st_q;
        if (wr_enable) st_d.enable = reg_wdata[NUM_SRC-1:0];
        if (wr_thresh) st_d.thr    = reg_wdata[THR_W-1:0];
        st_d.irq = |(qual_next & st_d.enable);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.thr    <= THR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_STATUS: reg_rdata = DATA_W'(status_now);
            ADDR_ENABLE: reg_rdata = DATA_W'(st_q.enable);
            ADDR_THRESH: reg_rdata = DATA_W'(st_q.thr);
            default:     reg_rdata = '0;
        endcase
    end

    assign irq_out = st_q.irq;
endmodule

// File: rtl/usb_irq_checker.sv
module usb_irq_checker
    import usb_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_SRC-1:0] evt_pulse,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq_out,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] enable_q,
    input logic              boundary
);
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> |(status_q & enable_q)); // R10

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_ENABLE) |-> (reg_rdata[DATA_W-1:NUM_SRC] == '0)); // R2

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> ((status_q & $past(evt_pulse)) == $past(evt_pulse))); // R5

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == ADDR_STATUS && ((reg_wdata[NUM_SRC-1:0] & ~evt_pulse) != '0))
        |=> ((status_q & $past(reg_wdata[NUM_SRC-1:0] & ~evt_pulse)) == '0)); // R4

    AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == ADDR_ENABLE && reg_wdata[NUM_SRC-1:0] == '0)
        |=> !irq_out); // R9

    AST_DEFER_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_out) && ((status_q & enable_q & ~DEFER_MASK) == '0)
         && (enable_q == $past(enable_q))) |-> $past(boundary)); // R7
endmodule

bind usb_irq_aggregator usb_irq_checker #(.DATA_W(DATA_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .status_q  (status_now),
    .enable_q  (st_q.enable),
    .boundary  (tick_boundary)
);

// File: tb/test_usb_irq_aggregator.sv
module test_usb_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  evt_pulse = '0;
    logic        uframe_tick = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    bit [5:0] m_status, m_en, m_qual;
    int       m_thr, m_cnt;
    bit       m_irq;

    always #5 clk = ~clk;

    usb_irq_aggregator i_usb_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .uframe_tick(uframe_tick),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    function automatic int interval_of(int v);
        case (v)
            1, 2, 4, 8, 16, 32, 64: return v;
            default:                return 8;
        endcase
    endfunction

    function automatic bit is_deferred(int i);
        return (i == 0) || (i == 1) || (i == 5);
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        case (a)
            8'h24:   return {26'd0, m_status};
            8'h28:   return {26'd0, m_en};
            8'h2C:   return 32'(m_thr);
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge(bit wr, logic [7:0] a, logic [31:0] wd, bit [5:0] ev, bit tk);
        bit [5:0] ns;
        bit       bnd;
        bnd = tk && (m_cnt >= interval_of(m_thr) - 1);
        for (int i = 0; i < 6; i++) begin
            ns[i] = ev[i] || (m_status[i] && !(wr && a == 8'h24 && wd[i]));
        end
        for (int i = 0; i < 6; i++) begin
            if (is_deferred(i)) m_qual[i] = ns[i] && (m_qual[i] || (bnd && m_status[i]));
            else                m_qual[i] = ns[i];
        end
        m_status = ns;
        if (tk) m_cnt = bnd ? 0 : m_cnt + 1;
        if (wr && a == 8'h28) m_en = wd[5:0];
        if (wr && a == 8'h2C) m_thr = int'(wd[6:0]);
        m_irq = 1'b0;
        for (int i = 0; i < 6; i++) if (m_qual[i] && m_en[i]) m_irq = 1'b1;
    endtask

    task automatic step(bit wr, logic [7:0] a, logic [31:0] wd, bit [5:0] ev, bit tk, string tag);
        @(negedge clk);
        reg_wr_en = wr; reg_addr = a; reg_wdata = wd; evt_pulse = ev; uframe_tick = tk;
        @(posedge clk);
        model_edge(wr, a, wd, ev, tk);
        #1;
        chk(irq_out === m_irq, {tag, " irq_out"}, 32'(irq_out), 32'(m_irq));
        chk(reg_rdata === model_read(a), {tag, " read"}, reg_rdata, model_read(a));
    endtask

    task automatic idle(logic [7:0] a, bit tk, int n, string tag);
        for (int k = 0; k < n; k++) step(0, a, 0, 0, tk, tag);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_status = 0; m_en = 0; m_qual = 0; m_thr = 8; m_cnt = 0; m_irq = 0;
        repeat (3) @(posedge clk);
        #1;
        chk(irq_out === 1'b0, "R1 irq in reset", 32'(irq_out), 0);
        reg_addr = 8'h2C; #1;
        chk(reg_rdata === 32'd8, "R1 threshold reset", reg_rdata, 8);
        reg_addr = 8'h28; #1;
        chk(reg_rdata === 32'd0, "R1 enable reset", reg_rdata, 0);
        @(negedge clk); rst_n = 1'b1;
        step(0, 8'h24, 0, 0, 0, "R1 status reset");

        // R2: enable width and reserved bits
        step(1, 8'h28, 32'hFFFF_FFFF, 0, 0, "R2 enable all ones");
        chk(reg_rdata === 32'h3F, "R2 reserved read zero", reg_rdata, 32'h3F);
        step(1, 8'h28, 32'h0, 0, 0, "R2 enable clear");

        // R3: flags latch while disabled, no interrupt
        step(0, 8'h24, 0, 6'h3F, 0, "R3 latch disabled");
        chk(reg_rdata === 32'h3F && irq_out === 1'b0, "R3 polled flags", reg_rdata, 32'h3F);
        idle(8'h24, 0, 2, "R3 sticky");

        // R4: write-one-to-clear
        step(1, 8'h24, 32'h05, 0, 0, "R4 clear bits 0 and 2");
        chk(reg_rdata === 32'h3A, "R4 partial clear", reg_rdata, 32'h3A);
        step(1, 8'h24, 32'h0, 0, 0, "R4 zero write no effect");
        chk(reg_rdata === 32'h3A, "R4 zero write", reg_rdata, 32'h3A);
        step(1, 8'h24, 32'h3F, 0, 0, "R4 clear all");

        // R5: set wins over clear
        step(1, 8'h24, 32'h04, 6'h04, 0, "R5 set and clear together");
        chk(reg_rdata[2] === 1'b1, "R5 set wins", reg_rdata, 32'h04);
        step(1, 8'h24, 32'h3F, 0, 0, "R5 cleanup");

        // R6: immediate sources
        step(1, 8'h28, 32'h3F, 0, 0, "R6 enable all");
        step(0, 8'h24, 0, 6'h08, 0, "R6 rollover immediate");
        chk(irq_out === 1'b1, "R6 irq at once", 32'(irq_out), 1);
        step(1, 8'h24, 32'h08, 0, 0, "R10 ack rollover");
        chk(irq_out === 1'b0, "R10 irq falls", 32'(irq_out), 0);
        step(0, 8'h24, 0, 6'h10, 0, "R6 system error immediate");
        step(1, 8'h24, 32'h10, 6'h04, 0, "R6 port change while acking");
        step(1, 8'h24, 32'h04, 0, 0, "R10 ack port change");

        // R7: deferred sources, interval 4
        step(1, 8'h2C, 32'h04, 0, 0, "R8 program 4");
        idle(8'h24, 1, 6, "R7 align counter");
        step(0, 8'h24, 0, 6'h01, 0, "R7 transfer done");
        chk(irq_out === 1'b0, "R7 not immediate", 32'(irq_out), 0);
        idle(8'h24, 0, 5, "R7 no ticks no irq");
        idle(8'h24, 1, 6, "R7 waits for boundary");
        step(1, 8'h24, 32'h01, 0, 0, "R10 ack deferred");
        step(0, 8'h24, 0, 6'h01, 1, "R10 re-arm needs new boundary");
        idle(8'h24, 1, 5, "R10 re-armed wait");
        step(1, 8'h24, 32'h3F, 0, 0, "R10 cleanup");

        // R9: enable clear drops irq, flag kept
        step(0, 8'h24, 0, 6'h10, 0, "R9 raise");
        step(1, 8'h28, 32'h0, 0, 0, "R9 disable");
        chk(irq_out === 1'b0, "R9 dropped next clock", 32'(irq_out), 0);
        step(0, 8'h24, 0, 0, 0, "R9 flag kept");
        chk(reg_rdata === 32'h10, "R9 flag unchanged", reg_rdata, 32'h10);
        step(1, 8'h28, 32'h3F, 0, 0, "R9 re-enable");
        step(1, 8'h24, 32'h3F, 0, 0, "R9 cleanup");

        // R8: illegal value falls back to 8, then 1 and 64
        step(1, 8'h2C, 32'h03, 0, 0, "R8 illegal value");
        chk(reg_rdata === 32'h03, "R8 raw readback", reg_rdata, 32'h03);
        step(0, 8'h24, 0, 6'h02, 1, "R8 error event");
        idle(8'h24, 1, 12, "R8 fallback interval");
        step(1, 8'h24, 32'h3F, 0, 0, "R8 cleanup");
        step(1, 8'h2C, 32'h01, 0, 0, "R8 program 1");
        step(0, 8'h24, 0, 6'h20, 0, "R8 async advance");
        idle(8'h24, 1, 3, "R8 interval 1");
        step(1, 8'h24, 32'h3F, 0, 0, "R8 cleanup");
        step(1, 8'h2C, 32'h40, 0, 0, "R8 program 64");
        step(0, 8'h24, 0, 6'h21, 0, "R8 two deferred");
        idle(8'h24, 1, 70, "R8 interval 64");
        step(1, 8'h24, 32'h20, 0, 0, "R10 one of two acked");
        step(1, 8'h24, 32'h01, 0, 0, "R10 last acked");
        chk(irq_out === 1'b0, "R10 all acked", 32'(irq_out), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule